// File: doc/BRIEF.md
# Input Change Interrupt Detector

This block watches an 8-bit general-purpose port. It raises an active-low interrupt whenever a pin set as an input no longer matches the value that software last captured from the port. The captured value, called the snapshot, is the content of the port's input register. A bus interface elsewhere in the chip returns it as read data. When that interface reads the input register, it pulses a strobe at the acknowledge point of the read. The strobe refreshes the snapshot from the current pin levels and drops the interrupt.

The pins come from pads and are asynchronous, so they pass through a two-flop synchroniser before any comparison. The interrupt is compared level against level rather than latched per edge. A pin that toggles away and then back, with no read in between, leaves the interrupt released again. The interrupt leaves the block as a registered open-drain pull enable together with its logical level.

Top module: `port_change_irq`

## Requirements
- R1: A rising or falling change on a pin whose direction bit is 1 (input) makes `int_n` go low on the third rising clock edge after the change is stable at `pin_raw`.
- R2: If the input pins return to the snapshot value and no read strobe occurs, `int_n` goes high again with the same three-edge latency.
- R3: A one-cycle pulse on `rd_input_ack` sets `int_n` high at the next rising edge. At that edge `snap_o` loads the synchronised levels of all pins.
- R4: A pin whose direction bit is 0 (output) never pulls `int_n` low, whatever its level.
- R5: Setting a direction bit from 0 to 1 while that pin differs from the snapshot drives `int_n` low on the next rising edge.
- R6: A change that reaches the synchroniser after a clear, including one that arrives while the read strobe is being taken, is reported again on `int_n`.
- R7: Once out of reset, `snap_o` changes only on a read strobe. Pin or direction activity without a strobe leaves it unchanged.
- R8: During and after reset `int_n` is high. `snap_o` takes the current pin levels by the third rising edge after reset release, without raising the interrupt.
- R9: `int_drive_en` is 1 exactly when `int_n` is 0, so an open-drain pad pulls low only while the interrupt is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_raw | input | 8 | Asynchronous pin levels from the pads |
| dir_in | input | 8 | Direction per pin, 1 = input, 0 = output |
| rd_input_ack | input | 1 | One-cycle strobe at the acknowledge of an input register read |
| snap_o | output | 8 | Snapshot, the input register contents |
| int_n | output | 1 | Interrupt level, low when asserted |
| int_drive_en | output | 1 | Open-drain pull-down enable for the interrupt pad |

## Verification
The bench toggles a pin away and back to show that the interrupt self-clears. A design that latches per edge would hold `int_n` low at that point. It also flips an output pin and then turns that pin into an input. A design that skips direction masking would fire early, and one that masks too hard would stay silent. A pin change is aligned with the read strobe, so the refreshed snapshot misses it. A design that blocked detection after a clear, or sampled the unsynchronised pins, would never report that change. Reset with the pins held away from zero checks that the snapshot arms to the pin levels instead of raising a false interrupt.

// File: rtl/port_change_irq_pkg.sv
package port_change_irq_pkg;

    localparam int PORT_W    = 8;
    localparam int SYNC_DEPTH = 2;
    localparam int ARM_CYC   = SYNC_DEPTH + 1;
    localparam int ARM_W     = $clog2(ARM_CYC + 1);

    typedef struct packed {
        logic [PORT_W-1:0] snap;
        logic              irq;
        logic [ARM_W-1:0]  arm_cnt;
    } det_state_t;

endpackage

// File: rtl/pin_sync.sv
module pin_sync #(
    parameter int WIDTH  = 8,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_async,
    output logic [WIDTH-1:0] q_sync
);
    logic [WIDTH-1:0] stage_d [STAGES];
    logic [WIDTH-1:0] stage_q [STAGES];

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_comb stage_d[g] = d_async;
            end else begin : g_next
                always_comb stage_d[g] = stage_q[g-1];
            end
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q[g] <= '0;
                else        stage_q[g] <= stage_d[g];
            end
        end
    endgenerate

    assign q_sync = stage_q[STAGES-1];
endmodule

// File: rtl/change_detect.sv
module change_detect
    import port_change_irq_pkg::*;
#(
    parameter int WIDTH   = PORT_W,
    parameter int ARM_N   = ARM_CYC,
    parameter int CNT_W   = $clog2(ARM_N + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] pins_s,
    input  logic [WIDTH-1:0] dir_in,
    input  logic             rd_stb,
    output logic [WIDTH-1:0] snap,
    output logic             irq,
    output logic             armed
);
    typedef struct packed {
        logic [WIDTH-1:0] snap;
        logic             irq;
        logic [CNT_W-1:0] arm_cnt;
    } st_t;

    localparam logic [CNT_W-1:0] ARM_LAST = CNT_W'(ARM_N);

    st_t st_d, st_q;
    logic [WIDTH-1:0] diff_in;
    logic             arm_done;

    always_comb begin
        st_d     = st_q;
        arm_done = (st_q.arm_cnt == ARM_LAST);
        diff_in  = (pins_s ^ st_q.snap) & dir_in;

        if (!arm_done) begin
            // fill window: track pins, keep interrupt released
            st_d.arm_cnt = st_q.arm_cnt + 1'b1;
            st_d.snap    = pins_s;
            st_d.irq     = 1'b0;
        end else if (rd_stb) begin
            st_d.snap = pins_s;
            st_d.irq  = 1'b0;
        end else begin
            st_d.irq  = |diff_in;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign snap  = st_q.snap;
    assign irq   = st_q.irq;
    assign armed = (st_q.arm_cnt == ARM_LAST);
endmodule

// File: rtl/port_change_irq.sv
module port_change_irq
    import port_change_irq_pkg::*;
#(
    parameter int WIDTH      = PORT_W,
    parameter int SYNC_STAGES = SYNC_DEPTH
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] pin_raw,
    input  logic [WIDTH-1:0] dir_in,
    input  logic             rd_input_ack,
    output logic [WIDTH-1:0] snap_o,
    output logic             int_n,
    output logic             int_drive_en
);
    localparam int ARM_N = SYNC_STAGES + 1;

    logic [WIDTH-1:0] pin_s;
    logic             irq;
    logic             armed;

    pin_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (pin_raw),
        .q_sync  (pin_s)
    );

    change_detect #(.WIDTH(WIDTH), .ARM_N(ARM_N)) u_det (
        .clk    (clk),
        .rst_n  (rst_n),
        .pins_s (pin_s),
        .dir_in (dir_in),
        .rd_stb (rd_input_ack),
        .snap   (snap_o),
        .irq    (irq),
        .armed  (armed)
    );

    assign int_n        = ~irq;
    assign int_drive_en = irq;
endmodule

// File: rtl/port_change_irq_chk.sv
module port_change_irq_chk #(
    parameter int WIDTH = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic [WIDTH-1:0] pin_s,
    input logic [WIDTH-1:0] dir_in,
    input logic             rd_input_ack,
    input logic             armed,
    input logic [WIDTH-1:0] snap_o,
    input logic             int_n,
    input logic             int_drive_en
);
    // R3
    rd_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_input_ack |=> int_n);

    // R3
    rd_loads_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_input_ack && armed) |=> (snap_o == $past(pin_s)));

    // R4
    out_only_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(int_n) |-> $past(|dir_in));

    // R2
    low_needs_diff_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!int_n && $past(armed)) |-> $past(|((pin_s ^ snap_o) & dir_in)));

    // R7
    snap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && !rd_input_ack) |=> $stable(snap_o));

    // R9
    od_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        int_drive_en != int_n);
endmodule

bind port_change_irq port_change_irq_chk #(.WIDTH(WIDTH)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .pin_s        (pin_s),
    .dir_in       (dir_in),
    .rd_input_ack (rd_input_ack),
    .armed        (armed),
    .snap_o       (snap_o),
    .int_n        (int_n),
    .int_drive_en (int_drive_en)
);

// File: tb/tb_port_change_irq.sv
module tb_port_change_irq;
    localparam int W = 8;
    localparam int NV = 13;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] pin_raw = 8'hA5;
    logic [W-1:0] dir_in = 8'hFF;
    logic         rd_input_ack = 1'b0;
    logic [W-1:0] snap_o;
    logic         int_n;
    logic         int_drive_en;

    int n_run = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    port_change_irq dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .pin_raw      (pin_raw),
        .dir_in       (dir_in),
        .rd_input_ack (rd_input_ack),
        .snap_o       (snap_o),
        .int_n        (int_n),
        .int_drive_en (int_drive_en)
    );

    // {pins, dir, rd, exp_int_n, exp_snap}
    localparam logic [25:0] VEC [NV] = '{
        {8'hA5, 8'hFF, 1'b0, 1'b1, 8'hA5},  // R8 armed, quiet
        {8'hA4, 8'hFF, 1'b0, 1'b0, 8'hA5},  // R1 falling bit0
        {8'hA5, 8'hFF, 1'b0, 1'b1, 8'hA5},  // R2 back to snapshot
        {8'hE5, 8'hFF, 1'b0, 1'b0, 8'hA5},  // R1 rising bit6
        {8'hE5, 8'hFF, 1'b1, 1'b1, 8'hE5},  // R3 read clears
        {8'h65, 8'hFF, 1'b0, 1'b0, 8'hE5},  // R6 change after clear
        {8'h65, 8'hFF, 1'b1, 1'b1, 8'h65},  // R3
        {8'h64, 8'hF0, 1'b0, 1'b1, 8'h65},  // R4 output pin change
        {8'h64, 8'hF1, 1'b0, 1'b0, 8'h65},  // R5 output to input
        {8'h64, 8'hF1, 1'b1, 1'b1, 8'h64},  // R3
        {8'h00, 8'h00, 1'b0, 1'b1, 8'h64},  // R4 all outputs
        {8'h00, 8'h0F, 1'b0, 1'b0, 8'h64},  // R5 low nibble to input
        {8'h04, 8'h0F, 1'b0, 1'b1, 8'h64}   // R2 / R7 no read
    };

    task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        tick(3);
        check("R8 reset int_n", {7'd0, int_n}, 8'h01);
        rst_n = 1'b1;
        tick(3);
        check("R8 snap armed", snap_o, 8'hA5);
        check("R8 int_n quiet", {7'd0, int_n}, 8'h01);

        for (int v = 0; v < NV; v++) begin
            pin_raw = VEC[v][25:18];
            dir_in  = VEC[v][17:10];
            tick(4);
            if (VEC[v][9]) begin
                rd_input_ack = 1'b1;
                tick(1);
                rd_input_ack = 1'b0;
            end
            check($sformatf("R1-vector %0d int_n", v), {7'd0, int_n}, {7'd0, VEC[v][8]});
            check($sformatf("R7 vector %0d snap", v), snap_o, VEC[v][7:0]);
            check("R9 drive enable", {7'd0, int_drive_en}, {7'd0, ~int_n});
        end

        // R1 latency: exactly three edges
        pin_raw = 8'h05;
        tick(2);
        check("R1 not yet at edge 2", {7'd0, int_n}, 8'h01);
        tick(1);
        check("R1 asserted at edge 3", {7'd0, int_n}, 8'h00);

        // R3 clear one edge after strobe
        rd_input_ack = 1'b1;
        tick(1);
        rd_input_ack = 1'b0;
        check("R3 cleared next edge", {7'd0, int_n}, 8'h01);
        check("R3 snap loaded", snap_o, 8'h05);

        // R6 change arriving with the read strobe
        pin_raw = 8'h07;
        rd_input_ack = 1'b1;
        tick(1);
        rd_input_ack = 1'b0;
        check("R6 snap missed new level", snap_o, 8'h05);
        tick(3);
        check("R6 re-reported", {7'd0, int_n}, 8'h00);

        // R8 reset mid-run with pins away from zero
        rst_n = 1'b0;
        pin_raw = 8'h3C;
        tick(1);
        check("R8 int released in reset", {7'd0, int_n}, 8'h01);
        rst_n = 1'b1;
        tick(3);
        check("R8 rearm snap", snap_o, 8'h3C);
        tick(3);
        check("R8 no false irq", {7'd0, int_n}, 8'h01);

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!finished) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule